// File: doc/BRIEF.md
# Memory Bit-Manipulation Execution Unit

This unit carries out the single-bit and masked memory operations of an extended 8-bit processor core against a byte-wide memory bus. The surrounding core has already decoded the addressing mode and resolved the operand address. It pulses `start` with the opcode, the accumulator value, the operand address and the address of the following relative-offset byte. The unit then drives the bus cycles on its own. On the final cycle it reports a zero-flag update, a branch decision, or nothing, depending on the operation.

The unit handles four operation kinds:

- Clear or set one bit of a memory byte.
- Test-and-set or test-and-reset of memory under an accumulator mask. The zero flag comes from the accumulator ANDed with the memory byte, while a different value is written back.
- Branch when a chosen memory bit is clear.
- Branch when a chosen memory bit is set. For the two branch kinds, the unit fetches the offset byte and hands it to the core together with the taken decision.

Read data is expected combinationally in the cycle in which `bus_rd` is high. A write takes effect at the clock edge that ends a cycle in which `bus_we` is high.

Top module: `bitop_unit`

## Requirements
- R1: After reset, and whenever no operation is in progress, `busy`, `bus_rd`, `bus_we`, `done`, `z_we` and `br_valid` are all low.
- R2: Opcodes with low nibble 0x7 and opcode bit 7 clear (bit-clear) read the byte at `op_addr`. In the next cycle they write that byte back to the same address with bit `opcode[6:4]` cleared. `done` is high in the write cycle.
- R3: Opcodes with low nibble 0x7 and opcode bit 7 set (bit-set) run the same two-cycle read-then-write sequence, but the write sets bit `opcode[6:4]`.
- R4: Opcodes 0x04 and 0x0C (test-and-set) run three cycles in this order: read `op_addr`, read the same address a second time, then write A OR M there. In the write cycle, `z_we` is high and `z_val` is 1 exactly when A AND M is zero.
- R5: Opcodes 0x14 and 0x1C (test-and-reset) run the same three cycles and write (NOT A) AND M, with `z_val` computed from A AND M.
- R6: Opcodes with low nibble 0xF read the byte at `op_addr`, then read the offset byte at `ofs_addr` in the next cycle, with `done` and `br_valid` high. `br_taken` is 1 when bit `opcode[6:4]` of the first byte equals `opcode[7]`: 0 selects branch-on-clear, 1 selects branch-on-set. `br_offset` carries the offset byte.
- R7: `bus_we` is high only in the final write cycle of a bit-clear, bit-set, test-and-set or test-and-reset operation, and never during branches. `z_we` is high only in the write cycle of test-and-set or test-and-reset, so every other operation leaves all flags unchanged.
- R8: A `start` with any opcode outside the groups above produces no bus cycle and no strobe.
- R9: A `start` that arrives while `busy` is high is ignored, and the operation already in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse for one operation |
| opcode | input | 8 | Instruction opcode |
| acc | input | 8 | Accumulator value |
| op_addr | input | 16 | Resolved operand address |
| ofs_addr | input | 16 | Address of the relative-offset byte (branches) |
| rdata | input | 8 | Memory read data |
| bus_addr | output | 16 | Memory address |
| bus_rd | output | 1 | Read cycle |
| bus_we | output | 1 | Write cycle |
| bus_wdata | output | 8 | Write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of the operation |
| z_we | output | 1 | Zero flag update strobe |
| z_val | output | 1 | New zero flag value |
| br_valid | output | 1 | Branch decision valid |
| br_taken | output | 1 | Branch taken |
| br_offset | output | 8 | Signed relative offset |

## Verification
The bench targets the following faults:

- **Bit index:** it uses bit indices 0, 3, 5 and 7. A design that takes the index from the wrong opcode field would write or test the wrong bit.
- **Masked operations:** it uses accumulator and memory pairs whose AND is zero while their OR is not. A design that derives Z from the written value, or that inverts the wrong operand for test-and-reset, would give the wrong flag or data.
- **Branches:** it covers both branch polarities with the bit both set and clear, and uses offsets of 0x80 and 0x7F. A swapped polarity or a stale offset would show up here.
- **Cycle order and ignored starts:** illegal opcodes and a second `start` during an operation must leave the bus silent or untouched. A design that skips the second read in test-and-set would be one cycle short.

// File: rtl/bitop_unit.sv
module bitop_unit #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] acc,
  input  logic [AW-1:0] op_addr,
  input  logic [AW-1:0] ofs_addr,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rd,
  output logic          bus_we,
  output logic [DW-1:0] bus_wdata,
  output logic          busy,
  output logic          done,
  output logic          z_we,
  output logic          z_val,
  output logic          br_valid,
  output logic          br_taken,
  output logic [DW-1:0] br_offset
);
  localparam int BW = $clog2(DW);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_MOD, S_WR, S_OFS} st_t;
  typedef enum logic [1:0] {K_BIT, K_TST, K_BR} kind_t;

  st_t           st;
  kind_t         kind_q, kind_d;
  logic [7:0]    op_q;
  logic [DW-1:0] acc_q, data_q, mask;
  logic [AW-1:0] addr_q, oaddr_q;
  logic          legal;

  always_comb begin
    legal  = 1'b1;
    kind_d = K_BIT;
    if (opcode[3:0] == 4'h7)                               kind_d = K_BIT;
    else if (opcode[3:0] == 4'hF)                          kind_d = K_BR;
    else if (opcode[7:5] == 3'b000 && opcode[2:0] == 3'b100) kind_d = K_TST;
    else legal = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      kind_q  <= K_BIT;
      op_q    <= '0;
      acc_q   <= '0;
      addr_q  <= '0;
      oaddr_q <= '0;
      data_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start && legal) begin
          st      <= S_RD;
          kind_q  <= kind_d;
          op_q    <= opcode;
          acc_q   <= acc;
          addr_q  <= op_addr;
          oaddr_q <= ofs_addr;
        end
        S_RD: begin
          data_q <= rdata;
          case (kind_q)
            K_TST:   st <= S_MOD;
            K_BR:    st <= S_OFS;
            default: st <= S_WR;
          endcase
        end
        S_MOD:   st <= S_WR;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mask = DW'(1) << op_q[4 +: BW];

  always_comb begin
    if (kind_q == K_TST)
      bus_wdata = op_q[4] ? (~acc_q & data_q) : (acc_q | data_q);
    else
      bus_wdata = op_q[7] ? (data_q | mask) : (data_q & ~mask);
  end

  assign bus_addr  = (st == S_OFS) ? oaddr_q : addr_q;
  assign bus_rd    = (st == S_RD) || (st == S_MOD) || (st == S_OFS);
  assign bus_we    = (st == S_WR);
  assign busy      = (st != S_IDLE);
  assign done      = (st == S_WR) || (st == S_OFS);
  assign z_we      = (st == S_WR) && (kind_q == K_TST);
  assign z_val     = ((acc_q & data_q) == '0);
  assign br_valid  = (st == S_OFS);
  assign br_taken  = (data_q[op_q[4 +: BW]] == op_q[7]);
  assign br_offset = rdata;
endmodule

module bitop_unit_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_we,
  input logic          busy,
  input logic          done,
  input logic          z_we,
  input logic          br_valid
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_rd && !bus_we && !done && !z_we && !br_valid); // R1
  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> $past(bus_rd) && bus_addr == $past(bus_addr)); // R2
  AST_WRITE_IS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> done && !br_valid && !bus_rd); // R7
  AST_ZFLAG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    z_we |-> bus_we && $past(bus_rd) && $past(bus_rd, 2)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_BRANCH_READS: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> bus_rd && done && $past(bus_rd)); // R6
endmodule

bind bitop_unit bitop_unit_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_we(bus_we), .busy(busy), .done(done), .z_we(z_we), .br_valid(br_valid)
);

// File: tb/tb_bitop_unit.sv
module tb_bitop_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic        rd, we, dn, zwe, zv, bv, bt;
    logic [15:0] addr;
    logic [7:0]  wd, ofs;
    string       req;
  } rec_t;

  logic        clk = 0, rst_n = 0, start = 0;
  logic [7:0]  opcode = 0, acc = 0;
  logic [15:0] op_addr = 0, ofs_addr = 0;
  logic [7:0]  rdata;
  logic [15:0] bus_addr;
  logic        bus_rd, bus_we, busy, done, z_we, z_val, br_valid, br_taken;
  logic [7:0]  bus_wdata, br_offset;

  logic [7:0] mem [0:255];
  rec_t q[$];
  int checks = 0, errors = 0, cyc = 0;

  bitop_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rdata = mem[bus_addr[7:0]];
  always @(posedge clk) begin
    if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;
    cyc <= cyc + 1;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic compare();
    rec_t e;
    logic bad;
    string req;
    checks++;
    if (q.size() == 0) begin
      req = "R1/R8";
      bad = busy | bus_rd | bus_we | done | z_we | br_valid;
      if (bad) begin
        errors++;
        $display("FAIL %s idle: actual busy=%b rd=%b we=%b done=%b zwe=%b bv=%b expected all 0",
                 req, busy, bus_rd, bus_we, done, z_we, br_valid);
      end
      return;
    end
    e = q.pop_front();
    bad = (bus_rd !== e.rd) || (bus_we !== e.we) || (done !== e.dn) ||
          (z_we !== e.zwe) || (br_valid !== e.bv) || ((e.rd || e.we) && bus_addr !== e.addr) ||
          (e.we && bus_wdata !== e.wd) || (e.zwe && z_val !== e.zv) ||
          (e.bv && (br_taken !== e.bt || br_offset !== e.ofs));
    if (bad) begin
      errors++;
      $display("FAIL %s: actual rd=%b we=%b a=%h wd=%h dn=%b zwe=%b z=%b bv=%b bt=%b of=%h expected rd=%b we=%b a=%h wd=%h dn=%b zwe=%b z=%b bv=%b bt=%b of=%h",
        e.req, bus_rd, bus_we, bus_addr, bus_wdata, done, z_we, z_val, br_valid, br_taken, br_offset,
        e.rd, e.we, e.addr, e.wd, e.dn, e.zwe, e.zv, e.bv, e.bt, e.ofs);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  function automatic rec_t mk(logic rd, logic we, logic [15:0] a, logic [7:0] wd, logic dn,
                              logic zwe, logic zv, logic bv, logic bt, logic [7:0] of, string req);
    rec_t r;
    r.rd = rd; r.we = we; r.addr = a; r.wd = wd; r.dn = dn;
    r.zwe = zwe; r.zv = zv; r.bv = bv; r.bt = bt; r.ofs = of; r.req = req;
    return r;
  endfunction

  task automatic model(input logic [7:0] op, input logic [7:0] a,
                       input logic [15:0] ad, input logic [15:0] oa);
    logic [7:0] m;
    int b;
    m = mem[ad[7:0]];
    b = int'(op[6:4]);
    if (op[3:0] == 4'h7) begin
      logic [7:0] w;
      w = m;
      w[b] = op[7];
      q.push_back(mk(1, 0, ad, 0, 0, 0, 0, 0, 0, 0, op[7] ? "R3" : "R2"));
      q.push_back(mk(0, 1, ad, w, 1, 0, 0, 0, 0, 0, op[7] ? "R3 R7" : "R2 R7"));
    end else if (op[3:0] == 4'hF) begin
      q.push_back(mk(1, 0, ad, 0, 0, 0, 0, 0, 0, 0, "R6"));
      q.push_back(mk(1, 0, oa, 0, 1, 0, 0, 1, m[b] == op[7], mem[oa[7:0]], "R6 R7"));
    end else if (op == 8'h04 || op == 8'h0C || op == 8'h14 || op == 8'h1C) begin
      logic [7:0] w;
      w = op[4] ? (~a & m) : (a | m);
      q.push_back(mk(1, 0, ad, 0, 0, 0, 0, 0, 0, 0, op[4] ? "R5" : "R4"));
      q.push_back(mk(1, 0, ad, 0, 0, 0, 0, 0, 0, 0, op[4] ? "R5 reread" : "R4 reread"));
      q.push_back(mk(0, 1, ad, w, 1, 1, (a & m) == 0, 0, 0, 0, op[4] ? "R5" : "R4"));
    end
  endtask

  task automatic run(input logic [7:0] op, input logic [7:0] a,
                     input logic [15:0] ad, input logic [15:0] oa);
    opcode = op; acc = a; op_addr = ad; ofs_addr = oa; start = 1;
    model(op, a, ad, oa);
    step();
    start = 0;
    while (q.size() != 0) step();
    step();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    step();

    mem[8'h37] = 8'hFF; run(8'h37, 8'h00, 16'h0037, 16'h0000);
    mem[8'h10] = 8'h00; run(8'h87, 8'h00, 16'h0010, 16'h0000);
    mem[8'h11] = 8'h00; run(8'hF7, 8'h00, 16'h0011, 16'h0000);
    mem[8'h12] = 8'hFF; run(8'h77, 8'h00, 16'h0012, 16'h0000);
    mem[8'h13] = 8'h5A; run(8'h07, 8'h00, 16'h0013, 16'h0000);

    mem[8'h20] = 8'hF0; run(8'h04, 8'h0F, 16'h0020, 16'h0000);
    mem[8'h21] = 8'h24; run(8'h0C, 8'h3C, 16'h1221, 16'h0000);
    mem[8'h22] = 8'h3C; run(8'h14, 8'h0F, 16'h0022, 16'h0000);
    mem[8'h23] = 8'h0F; run(8'h1C, 8'hF0, 16'h4523, 16'h0000);

    mem[8'h30] = 8'h00; mem[8'h31] = 8'h80; run(8'h2F, 8'h00, 16'h0030, 16'h0031);
    mem[8'h32] = 8'h04; mem[8'h33] = 8'h7F; run(8'h2F, 8'h00, 16'h0032, 16'h0033);
    mem[8'h34] = 8'h20; mem[8'h35] = 8'hFE; run(8'hDF, 8'h00, 16'h0034, 16'h0035);
    mem[8'h36] = 8'hDF; mem[8'h38] = 8'h10; run(8'hDF, 8'h00, 16'h0036, 16'h0038);
    mem[8'h39] = 8'h80; mem[8'h3A] = 8'h01; run(8'hFF, 8'h00, 16'h0039, 16'h003A);

    run(8'h03, 8'hFF, 16'h0040, 16'h0041);
    run(8'hEA, 8'hFF, 16'h0040, 16'h0041);
    run(8'h0B, 8'hFF, 16'h0040, 16'h0041);
    run(8'h24, 8'hFF, 16'h0040, 16'h0041);

    mem[8'h50] = 8'h00;
    opcode = 8'hC7; acc = 0; op_addr = 16'h0050; ofs_addr = 0; start = 1;
    model(8'hC7, 8'h00, 16'h0050, 16'h0000);
    step();
    opcode = 8'h04; acc = 8'hFF; op_addr = 16'h0051; start = 1;
    step();
    start = 0;
    step();
    step();
    checks++;
    if (mem[8'h50] !== 8'h10 || mem[8'h51] !== 8'(8'h51 * 37 + 5)) begin
      errors++;
      $display("FAIL R9: actual m50=%h m51=%h expected m50=10 m51=%h",
               mem[8'h50], mem[8'h51], 8'(8'h51 * 37 + 5));
    end
    summary();
  end
endmodule